// File: doc/BRIEF.md
# DMA Transfer Count and Autoload Unit

This unit tracks how many transfers remain in a DMA block for one working channel. Software loads a 16-bit control word. The upper two bits give the kind of operation. The lower bits give the number of transfers minus one. Each step strobe from the transfer engine decrements the remaining count. On the final transfer the unit drives a terminal-count pulse. While the block runs, it also drives a marker pulse every 128 transfers, counted back from the end of the block.

A second register holds a reload word. When autoload is enabled in the mode register, the cycle after a terminal count becomes an update cycle. During that cycle the update flag reads one and step strobes are ignored. At the end of the cycle the reload word is copied into the working channel, so the next block starts without software help. A sticky status bit records that a terminal count occurred and is cleared by a status-read strobe.

Register write addresses: 0 selects the working word, 1 selects the reload word, 2 selects the mode register (bit 0 enables autoload).

Top module: `dma_count_reload`

## Requirements
- R1: Writing the working word with count field N (bits 13:0) makes the channel active. The channel then accepts exactly N+1 step strobes. `tc` is high combinationally with the (N+1)th strobe and low with every earlier one.
- R2: `op_type` shows bits 15:14 of the current working word. `op_onehot` decodes it as bit 0 = verify (00), bit 1 = write (01), bit 2 = read (10), and is all zero for the illegal code 11.
- R3: `mark` is high with an accepted step strobe whenever the remaining count field has its low 7 bits equal to zero. It therefore pulses every 128 transfers counted back from the last transfer, and on the last transfer itself.
- R4: After a terminal count with autoload disabled, `active` drops to 0. Later step strobes produce neither `tc` nor `mark` until the working word is written again.
- R5: `tc_status` is set by a terminal count and stays set until a `stat_rd` strobe clears it. If a terminal count and a read occur in the same cycle, the bit ends up set.
- R6: With autoload enabled, the cycle after a terminal count has `update_flag` high for exactly one cycle. After that cycle, `op_type` and the count come from the reload word, and `active` stays 1.
- R7: Step strobes during the update cycle are ignored: they produce no `tc` and no `mark`, and they do not consume a transfer of the reloaded block.
- R8: The synchronous active-low reset clears the mode register, `tc_status`, `update_flag`, `active` and both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 working, 1 reload, 2 mode |
| wr_data | input | 16 | Write data: type in 15:14, count-minus-one in 13:0 |
| step | input | 1 | One transfer completed this cycle |
| stat_rd | input | 1 | Status read strobe, clears the sticky bit |
| tc | output | 1 | Terminal count, high with the last accepted step |
| mark | output | 1 | Marker pulse every 128 transfers from block end |
| op_type | output | 2 | Operation type of the working word |
| op_onehot | output | 3 | Decoded type {read, write, verify} |
| tc_status | output | 1 | Sticky terminal-count status |
| update_flag | output | 1 | High during the autoload update cycle |
| active | output | 1 | Working channel holds transfers still to run |

## Verification
The hardest case to reach from the ports is a step strobe that lands inside the one-cycle update window. The stimulus enables autoload and runs a short block to its terminal count. It then issues a step on the very next cycle. The bench checks that this step is ignored, and then counts the reloaded block's steps to confirm the ignored step took no transfer. The marker spacing needs a block longer than two intervals, so a 301-transfer block is run and every marker position is checked.

// File: rtl/dmatc_pkg.sv
// Shared encodings for the DMA transfer-count unit.
// Assumes a 2-bit operation field above the count field in each word.
package dmatc_pkg;
    typedef enum logic [1:0] {
        OP_VERIFY  = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ILLEGAL = 2'b11
    } op_kind_e;

    localparam logic [1:0] ADDR_WORK   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_MODE   = 2'd2;

    localparam int OP_W = 2;
endpackage

// File: rtl/dmatc_op_decode.sv
// Decodes the operation-type field into one-hot strobes.
// Assumes the encoding in dmatc_pkg; the illegal code decodes to all zero.
module dmatc_op_decode
    import dmatc_pkg::*;
#(
    parameter int N_KINDS = 3
) (
    input  logic [OP_W-1:0]    op,
    output logic [N_KINDS-1:0] onehot
);
    // One strobe per legal code; code k lights bit k.
    for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
        assign onehot[k] = (op == OP_W'(k));
    end
endmodule

// File: rtl/dmatc_status.sv
// Sticky terminal-count status bit with clear-on-read.
// Assumes a set and a read in the same cycle must not lose the event.
module dmatc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tc,
    input  logic rd,
    output logic status
);
    // Set on terminal count, clear on read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)  status <= 1'b0;
        else if (tc) status <= 1'b1;
        else if (rd) status <= 1'b0;
    end

    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n) tc |=> status);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n) (status && !rd) |=> status);
endmodule

// File: rtl/dmatc_reload_ctl.sv
// Holds the reload word and the mode register and sequences the update cycle.
// Assumes one update cycle immediately follows each terminal count when
// autoload is enabled.
module dmatc_reload_ctl #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reload,
    input  logic              wr_mode,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tc,
    output logic [WORD_W-1:0] reload_word,
    output logic              autoload,
    output logic              upd
);
    // Reload word register, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_word <= '0;
        else if (wr_reload) reload_word <= wr_data;
    end

    // Mode register: bit 0 enables autoload.
    always_ff @(posedge clk) begin
        if (!rst_n)       autoload <= 1'b0;
        else if (wr_mode) autoload <= wr_data[0];
    end

    // Update cycle flag: one cycle after a terminal count in autoload mode.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= tc && autoload;
    end

    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n) upd |=> !upd);
    a_r6_after_tc: assert property (@(posedge clk) disable iff (!rst_n) upd |-> $past(tc));
endmodule

// File: rtl/dmatc_counter.sv
// Working-channel count register with terminal-count and marker decode.
// Assumes a software write wins over a step in the same cycle, and that steps
// are ignored while an update cycle is running.
module dmatc_counter
    import dmatc_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int MARK_LOG2 = 7,
    localparam int WORD_W   = CNT_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cpu,
    input  logic [WORD_W-1:0] cpu_word,
    input  logic              load_reload,
    input  logic [WORD_W-1:0] reload_word,
    input  logic              step,
    input  logic              upd,
    input  logic              autoload,
    output logic [CNT_W-1:0]  count,
    output logic [OP_W-1:0]   op,
    output logic              active,
    output logic              tc,
    output logic              mark
);
    logic fire;
    logic last;

    // A step counts only for a live channel outside update and write cycles.
    always_comb begin
        fire = step && active && !upd && !load_cpu;
        last = (count == '0);
        tc   = fire && last;
        mark = fire && (count[MARK_LOG2-1:0] == '0);
    end

    // Count, type and activity state of the working channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            op     <= '0;
            active <= 1'b0;
        end else if (load_cpu) begin
            count  <= cpu_word[CNT_W-1:0];
            op     <= cpu_word[WORD_W-1:CNT_W];
            active <= 1'b1;
        end else if (load_reload) begin
            count  <= reload_word[CNT_W-1:0];
            op     <= reload_word[WORD_W-1:CNT_W];
            active <= 1'b1;
        end else if (fire) begin
            if (last) active <= autoload;
            else      count  <= count - 1'b1;
        end
    end

    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last) |=> (count == $past(count) - 1'b1));
    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoload) |=> !active);
endmodule

// File: rtl/dma_count_reload.sv
// Top of the DMA transfer-count and autoload unit.
// Assumes one working and one reload channel; address increment is elsewhere.
module dma_count_reload
    import dmatc_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int MARK_LOG2 = 7,
    localparam int WORD_W   = CNT_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              step,
    input  logic              stat_rd,
    output logic              tc,
    output logic              mark,
    output logic [OP_W-1:0]   op_type,
    output logic [2:0]        op_onehot,
    output logic              tc_status,
    output logic              update_flag,
    output logic              active
);
    logic              wr_work, wr_reload, wr_mode;
    logic [WORD_W-1:0] reload_word;
    logic              autoload;
    logic [CNT_W-1:0]  count;

    // Address decode of the write port.
    always_comb begin
        wr_work   = wr_en && (wr_addr == ADDR_WORK);
        wr_reload = wr_en && (wr_addr == ADDR_RELOAD);
        wr_mode   = wr_en && (wr_addr == ADDR_MODE);
    end

    dmatc_reload_ctl #(.WORD_W(WORD_W)) u_reload (
        .clk(clk), .rst_n(rst_n), .wr_reload(wr_reload), .wr_mode(wr_mode),
        .wr_data(wr_data), .tc(tc), .reload_word(reload_word),
        .autoload(autoload), .upd(update_flag)
    );

    dmatc_counter #(.CNT_W(CNT_W), .MARK_LOG2(MARK_LOG2)) u_count (
        .clk(clk), .rst_n(rst_n), .load_cpu(wr_work), .cpu_word(wr_data),
        .load_reload(update_flag), .reload_word(reload_word), .step(step),
        .upd(update_flag), .autoload(autoload), .count(count), .op(op_type),
        .active(active), .tc(tc), .mark(mark)
    );

    dmatc_status u_status (
        .clk(clk), .rst_n(rst_n), .tc(tc), .rd(stat_rd), .status(tc_status)
    );

    dmatc_op_decode #(.N_KINDS(3)) u_dec (.op(op_type), .onehot(op_onehot));

    a_r7_quiet_update: assert property (@(posedge clk) disable iff (!rst_n)
        update_flag |-> (!tc && !mark));
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(op_onehot));
endmodule

// File: tb/dma_count_reload_tb.sv
// Directed bench for dma_count_reload: one task per scenario.
module dma_count_reload_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        step = 1'b0;
    logic        stat_rd = 1'b0;
    logic        tc, mark, tc_status, update_flag, active;
    logic [1:0]  op_type;
    logic [2:0]  op_onehot;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_count_reload u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .step(step), .stat_rd(stat_rd), .tc(tc),
        .mark(mark), .op_type(op_type), .op_onehot(op_onehot),
        .tc_status(tc_status), .update_flag(update_flag), .active(active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    // One step strobe; tc and mark captured before the edge.
    task automatic step_once(output logic t, output logic m);
        @(negedge clk); step = 1'b1; #1 t = tc; m = mark;
        @(posedge clk); #1 step = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 active", active, 0);
        chk("R8 tc_status", tc_status, 0);
        chk("R8 update_flag", update_flag, 0);
        chk("R8 op_type", op_type, 0);
    endtask

    task automatic t_decode();
        int exp1h [4] = '{1, 2, 4, 0};
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, {k[1:0], 14'd5});
            chk("R2 op_type", op_type, k);
            chk("R2 op_onehot", op_onehot, exp1h[k]);
        end
    endtask

    task automatic t_count();
        logic t, m;
        wr(2'd0, {2'b01, 14'd3});
        chk("R1 active after load", active, 1);
        for (int i = 0; i < 4; i++) begin
            step_once(t, m);
            chk("R1 tc position", t, (i == 3) ? 1 : 0);
        end
        chk("R4 inactive after tc", active, 0);
        step_once(t, m);
        chk("R4 step ignored tc", t, 0);
        chk("R4 step ignored mark", m, 0);
    endtask

    task automatic t_mark();
        logic t, m;
        int marks = 0;
        int first = -1;
        int tcs = 0;
        wr(2'd0, {2'b10, 14'd300});
        for (int i = 0; i < 301; i++) begin
            step_once(t, m);
            if (m) begin
                marks++;
                if (first < 0) first = i;
            end
            if (t) tcs++;
            if (t) chk("R3 mark on last transfer", m, 1);
        end
        chk("R3 mark count", marks, 3);
        chk("R3 first mark index", first, 44);
        chk("R1 single tc in long block", tcs, 1);
    endtask

    task automatic t_status();
        logic t, m;
        chk("R5 status set", tc_status, 1);
        repeat (3) @(posedge clk);
        #1 chk("R5 status held", tc_status, 1);
        @(negedge clk); stat_rd = 1'b1;
        @(posedge clk); #1 stat_rd = 1'b0;
        chk("R5 cleared by read", tc_status, 0);
        wr(2'd0, {2'b00, 14'd0});
        @(negedge clk); step = 1'b1; stat_rd = 1'b1; #1 t = tc;
        @(posedge clk); #1 step = 1'b0; stat_rd = 1'b0;
        chk("R5 tc with read tc", t, 1);
        chk("R5 set wins over read", tc_status, 1);
    endtask

    task automatic t_autoload();
        logic t, m;
        wr(2'd2, 16'd1);
        wr(2'd1, {2'b10, 14'd2});
        wr(2'd0, {2'b01, 14'd1});
        step_once(t, m);
        chk("R6 first step no tc", t, 0);
        step_once(t, m);
        chk("R6 tc at block end", t, 1);
        chk("R6 update flag up", update_flag, 1);
        chk("R6 active held", active, 1);
        step_once(t, m);
        chk("R7 tc in update cycle", t, 0);
        chk("R7 mark in update cycle", m, 0);
        chk("R6 update flag one cycle", update_flag, 0);
        chk("R6 type reloaded", op_type, 2);
        for (int i = 0; i < 3; i++) begin
            step_once(t, m);
            chk("R7 reloaded block length", t, (i == 2) ? 1 : 0);
        end
    endtask

    task automatic t_reset_mode();
        logic t, m;
        do_reset();
        chk("R8 status cleared", tc_status, 0);
        chk("R8 update cleared", update_flag, 0);
        wr(2'd0, {2'b00, 14'd0});
        step_once(t, m);
        chk("R8 tc after reset", t, 1);
        chk("R8 autoload cleared", update_flag, 0);
        chk("R8 no reload", active, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_count();
        t_mark();
        t_status();
        t_autoload();
        t_reset_mode();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule